// File: doc/BRIEF.md
# Burst SRAM address sequencer

This block is the address and cycle control front end of a synchronous burst SRAM. Each rising clock edge samples two active-low address strobes, an active-low advance input, three chip enables and an 18-bit address. From these the block keeps a registered word address for the array. It also tracks whether the device is selected and pulses a cycle-start flag whenever a new access begins on a selected device.

The two strobes differ. The controller strobe always takes a new address: when the enables do not select the device, it deselects the device. The processor strobe has effect only while the first enable is low. When that enable is high, the processor strobe is dropped, and the device keeps its selection state and its address. Once an address is loaded, the advance input steps through a 4-beat burst that wraps. Only the two low address bits take part in the count. A static order-select level picks either an upward count modulo 4 or an XOR of the start bits with the beat number.

Top module: `bsram_addr_seq`

## Requirements
- R1: After reset, word_addr is 0, chip_sel is 0 and cycle_start is 0.
- R2: When ctl_strobe_n is low at a clock edge, word_addr equals the sampled addr_in after that edge, and the burst beat restarts at 0.
- R3: When cpu_strobe_n is low and ce_a_n is low at a clock edge, the address is loaded exactly as in R2.
- R4: When cpu_strobe_n is low, ce_a_n is high and ctl_strobe_n is high, the strobe has no effect: with advance_n high, word_addr and chip_sel keep their values.
- R5: When ctl_strobe_n is low and ce_a_n is high, chip_sel is 0 after the edge.
- R6: A load sets chip_sel to 1 only if ce_a_n=0, ce_b=1 and ce_c_n=0. Any other combination sets it to 0.
- R7: With order_sel=0 (linear), after n advances from start value s the two low bits of word_addr are (s+n) mod 4.
- R8: With order_sel=1 (interleaved), after n advances from start value s the two low bits of word_addr are s XOR (n mod 4).
- R9: Bits 17:2 of word_addr do not change while advancing. After four advances the address is back at its start value, and the same four addresses repeat after that.
- R10: With no accepted strobe, word_addr is held when advance_n is high. It is also held when advance_n is low but chip_sel is 0.
- R11: When both strobes are low in the same cycle, the controller strobe's rule applies. With ce_a_n high this means deselection.
- R12: cycle_start is 1 for exactly the one cycle after a load that leaves chip_sel at 1, and 0 at all other times, including during advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every synchronous input is sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_strobe_n | input | 1 | Processor address strobe, active low |
| ctl_strobe_n | input | 1 | Controller address strobe, active low, wins over the processor strobe |
| advance_n | input | 1 | Burst advance, active low |
| ce_a_n | input | 1 | First chip enable, active low; also gates the processor strobe |
| ce_b | input | 1 | Second chip enable, active high |
| ce_c_n | input | 1 | Third chip enable, active low |
| order_sel | input | 1 | Static burst order: 0 linear, 1 interleaved (not registered) |
| addr_in | input | 18 | External word address |
| word_addr | output | 18 | Internal word address to the array |
| chip_sel | output | 1 | Device selected for the current cycle |
| cycle_start | output | 1 | One-cycle pulse marking a new selected access |

## Verification
Two cases are hard to reach: the processor strobe arriving while the first enable is high, and both strobes falling together. Each needs the device to already be selected with a known non-zero address, because otherwise "no effect" and "deselect" look the same at the ports. The bench first loads and selects a distinctive address. It then applies the dropped processor strobe and checks that both address and selection survive. After that it reselects and drives both strobes, and sees the controller's deselect win. The burst sweep covers every start value in both orders, past the wrap point.

// File: rtl/bsram_seq_pkg.sv
package bsram_seq_pkg;

  localparam int unsigned BURST_W = 2;

  typedef enum logic [1:0] {
    CMD_HOLD       = 2'd0,
    CMD_ADV        = 2'd1,
    CMD_LOAD_SEL   = 2'd2,
    CMD_LOAD_DESEL = 2'd3
  } seq_cmd_e;

  // Low address bits for a given start value and beat number.
  function automatic logic [BURST_W-1:0] burst_lo(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] beat,
    input logic               interleave
  );
    if (interleave) return start ^ beat;
    else            return start + beat;
  endfunction

  // Device selection from the three enables.
  function automatic logic enables_select(
    input logic ce_a_n, input logic ce_b, input logic ce_c_n
  );
    return !ce_a_n && ce_b && !ce_c_n;
  endfunction

endpackage

// File: rtl/bsram_cmd_decode.sv
module bsram_cmd_decode
  import bsram_seq_pkg::*;
(
  input  logic     cpu_strobe_n,
  input  logic     ctl_strobe_n,
  input  logic     advance_n,
  input  logic     ce_a_n,
  input  logic     ce_b,
  input  logic     ce_c_n,
  input  logic     sel_q,
  output seq_cmd_e cmd,
  output logic     cpu_dropped
);

  logic ctl_take;
  logic cpu_take;
  logic sel_next;

  assign ctl_take    = !ctl_strobe_n;
  assign cpu_take    = !cpu_strobe_n && !ce_a_n;
  assign cpu_dropped = !cpu_strobe_n && ce_a_n && ctl_strobe_n;
  assign sel_next    = enables_select(ce_a_n, ce_b, ce_c_n);

  always_comb begin
    if (ctl_take || cpu_take)
      cmd = sel_next ? CMD_LOAD_SEL : CMD_LOAD_DESEL;
    else if (!advance_n && sel_q)
      cmd = CMD_ADV;
    else
      cmd = CMD_HOLD;
  end

endmodule

// File: rtl/bsram_burst_ctr.sv
module bsram_burst_ctr
  import bsram_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  seq_cmd_e           cmd,
  input  logic [BURST_W-1:0] start_lo,
  input  logic               order_sel,
  output logic [BURST_W-1:0] lo_addr
);

  logic [BURST_W-1:0] base_q;
  logic [BURST_W-1:0] beat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
    end else begin
      case (cmd)
        CMD_LOAD_SEL, CMD_LOAD_DESEL: begin
          base_q <= start_lo;
          beat_q <= '0;
        end
        CMD_ADV: beat_q <= beat_q + 1'b1;
        default: ;
      endcase
    end
  end

  assign lo_addr = burst_lo(base_q, beat_q, order_sel);

endmodule

// File: rtl/bsram_addr_seq.sv
module bsram_addr_seq
  import bsram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_strobe_n,
  input  logic              ctl_strobe_n,
  input  logic              advance_n,
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] word_addr,
  output logic              chip_sel,
  output logic              cycle_start
);

  localparam int unsigned UP_W = ADDR_W - BURST_W;

  seq_cmd_e           cmd;
  logic               cpu_dropped;
  logic               load_evt;
  logic               adv_evt;
  logic [UP_W-1:0]    upper_q;
  logic [BURST_W-1:0] lo_addr;
  logic               sel_q;
  logic               start_q;

  bsram_cmd_decode u_dec (
    .cpu_strobe_n (cpu_strobe_n),
    .ctl_strobe_n (ctl_strobe_n),
    .advance_n    (advance_n),
    .ce_a_n       (ce_a_n),
    .ce_b         (ce_b),
    .ce_c_n       (ce_c_n),
    .sel_q        (sel_q),
    .cmd          (cmd),
    .cpu_dropped  (cpu_dropped)
  );

  assign load_evt = (cmd == CMD_LOAD_SEL) || (cmd == CMD_LOAD_DESEL);
  assign adv_evt  = (cmd == CMD_ADV);

  bsram_burst_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .start_lo  (addr_in[BURST_W-1:0]),
    .order_sel (order_sel),
    .lo_addr   (lo_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      sel_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      start_q <= (cmd == CMD_LOAD_SEL);
      if (load_evt) begin
        upper_q <= addr_in[ADDR_W-1:BURST_W];
        sel_q   <= (cmd == CMD_LOAD_SEL);
      end
    end
  end

  assign word_addr   = {upper_q, lo_addr};
  assign chip_sel    = sel_q;
  assign cycle_start = start_q;

endmodule

// File: rtl/bsram_seq_chk.sv
module bsram_seq_chk #(
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_strobe_n,
  input logic              ctl_strobe_n,
  input logic              advance_n,
  input logic              ce_a_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] addr_in,
  input logic [ADDR_W-1:0] word_addr,
  input logic              chip_sel,
  input logic              cycle_start,
  input logic              load_evt,
  input logic              adv_evt,
  input logic              cpu_dropped
);

  a_r2_ctl_loads: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_strobe_n |=> word_addr == $past(addr_in));

  a_r3_cpu_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_strobe_n && !ce_a_n) |=> word_addr == $past(addr_in));

  a_r4_cpu_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_dropped |=> chip_sel == $past(chip_sel));

  a_r5_ctl_deselects: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_strobe_n && ce_a_n) |=> !chip_sel);

  a_r7_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_evt && !order_sel) |=> word_addr[1:0] == $past(word_addr[1:0]) + 2'd1);

  a_r9_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(word_addr[ADDR_W-1:2]));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_evt && !adv_evt) |=> $stable(word_addr));

  a_r12_start_needs_sel: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start |-> chip_sel);

  a_r12_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> !cycle_start);

endmodule

bind bsram_addr_seq bsram_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cpu_strobe_n (cpu_strobe_n),
  .ctl_strobe_n (ctl_strobe_n),
  .advance_n    (advance_n),
  .ce_a_n       (ce_a_n),
  .order_sel    (order_sel),
  .addr_in      (addr_in),
  .word_addr    (word_addr),
  .chip_sel     (chip_sel),
  .cycle_start  (cycle_start),
  .load_evt     (load_evt),
  .adv_evt      (adv_evt),
  .cpu_dropped  (cpu_dropped)
);

// File: tb/tb_bsram_addr_seq.sv
module tb_bsram_addr_seq;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_strobe_n = 1'b1;
  logic        ctl_strobe_n = 1'b1;
  logic        advance_n = 1'b1;
  logic        ce_a_n = 1'b0;
  logic        ce_b = 1'b1;
  logic        ce_c_n = 1'b0;
  logic        order_sel = 1'b0;
  logic [17:0] addr_in = '0;
  logic [17:0] word_addr;
  logic        chip_sel;
  logic        cycle_start;

  int n_total = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  bsram_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .cpu_strobe_n(cpu_strobe_n),
    .ctl_strobe_n(ctl_strobe_n), .advance_n(advance_n), .ce_a_n(ce_a_n),
    .ce_b(ce_b), .ce_c_n(ce_c_n), .order_sel(order_sel), .addr_in(addr_in),
    .word_addr(word_addr), .chip_sel(chip_sel), .cycle_start(cycle_start)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cpu_strobe_n = 1'b1;
    ctl_strobe_n = 1'b1;
    advance_n    = 1'b1;
  endtask

  task automatic load_sel(input logic [17:0] a, input bit use_cpu);
    ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
    addr_in = a;
    if (use_cpu) cpu_strobe_n = 1'b0; else ctl_strobe_n = 1'b0;
    step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    logic [17:0] held;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 addr", int'(word_addr), 0);
    chk("R1 sel", int'(chip_sel), 0);
    chk("R1 start", int'(cycle_start), 0);

    // Burst sweep: every start, both orders, past the wrap.
    for (int ord = 0; ord < 2; ord++) begin
      for (int s = 0; s < 4; s++) begin
        logic [17:0] a;
        logic [15:0] up;
        up = 16'hA5C3 ^ 16'(s * 16'h1111 + ord * 16'h0F0F);
        a  = {up, 2'(s)};
        order_sel = ord[0];
        load_sel(a, ord == 1);
        chk(ord == 1 ? "R3 load" : "R2 load", int'(word_addr), int'(a));
        chk("R12 start after load", int'(cycle_start), 1);
        chk("R6 selected", int'(chip_sel), 1);
        for (int n = 1; n <= 6; n++) begin
          logic [1:0] lo;
          lo = (ord == 0) ? 2'((s + n) % 4) : 2'(s ^ (n % 4));
          advance_n = 1'b0;
          step();
          chk(ord == 0 ? "R7 linear" : "R8 interleaved",
              int'(word_addr[1:0]), int'(lo));
          chk("R9 upper fixed", int'(word_addr[17:2]), int'(up));
          chk("R12 no start on advance", int'(cycle_start), 0);
          if (n == 4) chk("R9 wrap", int'(word_addr), int'(a));
        end
      end
    end

    // Hold with no strobe and no advance.
    order_sel = 1'b0;
    load_sel(18'h2BEEF, 1'b0);
    held = word_addr;
    step();
    chk("R10 hold", int'(word_addr), int'(held));

    // Processor strobe with first enable high is dropped.
    ce_a_n = 1'b1;
    addr_in = 18'h01234;
    cpu_strobe_n = 1'b0;
    step();
    chk("R4 addr kept", int'(word_addr), int'(held));
    chk("R4 sel kept", int'(chip_sel), 1);
    chk("R4 no start", int'(cycle_start), 0);

    // Enable combinations through controller loads.
    for (int e = 0; e < 8; e++) begin
      logic exp_sel;
      ce_a_n = e[0]; ce_b = e[1]; ce_c_n = e[2];
      exp_sel = !e[0] && e[1] && !e[2];
      addr_in = 18'(18'h10000 + e * 5);
      ctl_strobe_n = 1'b0;
      step();
      chk("R6 enable decode", int'(chip_sel), int'(exp_sel));
      chk("R12 start tracks sel", int'(cycle_start), int'(exp_sel));
      chk("R2 load on deselect", int'(word_addr), int'(18'h10000 + e * 5));
      if (e[0]) chk("R5 ctl deselect", int'(chip_sel), 0);
    end

    // Advance while deselected has no effect (last combo left chip_sel 0).
    held = word_addr;
    advance_n = 1'b0;
    step();
    chk("R10 adv ignored when deselected", int'(word_addr), int'(held));
    chk("R10 still deselected", int'(chip_sel), 0);

    // Both strobes, first enable high: controller rule wins.
    load_sel(18'h3C0DE, 1'b1);
    chk("R11 setup sel", int'(chip_sel), 1);
    ce_a_n = 1'b1;
    addr_in = 18'h00777;
    cpu_strobe_n = 1'b0;
    ctl_strobe_n = 1'b0;
    step();
    chk("R11 ctl priority deselect", int'(chip_sel), 0);
    chk("R11 ctl priority load", int'(word_addr), int'(18'h00777));

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule